// File: doc/BRIEF.md
# Interrupt Enable and Reset-Cause Flag Registers

This block holds two byte-wide special-function registers at the base of a small register window. One register stores interrupt enables. The other stores interrupt flags and reset-cause flags. Software reaches both through a simple select/write/address bus with a combinational read path. Hardware event inputs set the flags: watchdog overflow, watchdog key violation, oscillator fault, external reset pin, and NMI pin edge. The block drives one request line per interrupt source. Each request is the enable ANDed with its flag.

Three active-low synchronous reset levels of different strength drive the block. Brown-out is the strongest, power-on is in the middle, and power-up-clear is the weakest. The levels are nested: a stronger reset always includes the weaker ones. Each bit belongs to one reset domain, so a reset-cause flag survives every reset weaker than the one that clears it. After restart, software reads these flags to learn why the chip was reset.

Top module: `sfr_intr_top`

## Requirements
- R1: The enable register has read/write bits at positions 0 (watchdog), 1 (oscillator fault), 4 (NMI) and 5 (access violation). All four clear to 0 under power-up-clear or any stronger reset. Positions 2, 3, 6 and 7 read 0 and ignore writes.
- R2: The enable register sits at offset IE_OFFSET (default 0) and the flag register at offset FL_OFFSET (default 1). Read data is combinational. It is 0 when the select is low or the offset matches neither register, and a write to any other offset changes no state.
- R3: Flag bit 0 (watchdog) is set by a watchdog overflow or a watchdog key violation. It clears only under power-on or brown-out reset, so a power-up-clear alone leaves it unchanged.
- R4: Flag bit 1 (oscillator fault) is 1 whenever the fault input is high. It returns to 1 under power-up-clear or any stronger reset. A software write of 0 clears it only while the fault input is low.
- R5: Flag bit 2 (brown-out) becomes 1 under brown-out reset. It keeps its value through power-on and power-up-clear resets, and software can write it.
- R6: Flag bit 3 (external reset) is set by the reset-pin event. It clears only under brown-out reset, so it survives power-on and power-up-clear resets.
- R7: Flag bit 4 (NMI) is set by the NMI edge input and clears under power-up-clear or any stronger reset.
- R8: Flag positions 5, 6 and 7 read 0 and ignore writes.
- R9: If a hardware set event and a software write of 0 hit the same flag in the same cycle, the flag ends up at 1.
- R10: irq_osc_o, irq_nmi_o and irq_accv_o each equal their enable bit ANDed with their flag. The access-violation request takes its flag from acc_viol_i. irq_wdt_o also requires wdt_interval_i to be high.
- R11: Bus writes are ignored while any reset level is asserted.
- R12: A brown-out reset applies the power-on and power-up-clear defaults as well. A power-on reset applies the power-up-clear defaults as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bor_n | input | 1 | Brown-out reset, active low, synchronous |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| puc_n | input | 1 | Power-up-clear reset, active low, synchronous |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (valid with bus_sel) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| wdt_key_err_i | input | 1 | Watchdog key violation pulse |
| wdt_interval_i | input | 1 | High when the watchdog runs as an interval timer |
| osc_fault_i | input | 1 | Oscillator fault present (level) |
| pin_rst_i | input | 1 | Reset pin triggered a reset (pulse) |
| nmi_edge_i | input | 1 | NMI pin edge detected (pulse) |
| acc_viol_i | input | 1 | Flash access-violation flag from outside |
| irq_wdt_o | output | 1 | Watchdog interval interrupt request |
| irq_osc_o | output | 1 | Oscillator fault interrupt request |
| irq_nmi_o | output | 1 | NMI request |
| irq_accv_o | output | 1 | Access violation interrupt request |

## Verification
The hardest state to reach is a partial reset that hits flags holding non-default values. For example, a power-up-clear must arrive while the watchdog and external-reset flags are set, and a power-on reset must arrive while the brown-out flag was written back to 1. The bench builds that state step by step: it sets each flag through its event input or a bus write, then applies the reset levels one at a time from weakest to strongest and reads the flag register after each one. It also aims a bus write at a register during a reset, and lines up a set event and a clearing write in the same cycle. A randomized phase then mixes events, writes and rare resets of every strength, and compares against the reference model on every clock.

// File: rtl/sfr_pkg.sv
// Package: bit positions and implemented-bit masks of the two registers.
// Assumes 8-bit registers; software decodes these positions, so they are fixed.
package sfr_pkg;
    localparam int SFR_DW = 8;

    localparam int IE_WDT  = 0;
    localparam int IE_OSC  = 1;
    localparam int IE_NMI  = 4;
    localparam int IE_ACCV = 5;

    localparam int FL_WDT  = 0;
    localparam int FL_OSC  = 1;
    localparam int FL_BOR  = 2;
    localparam int FL_RST  = 3;
    localparam int FL_NMI  = 4;

    localparam logic [SFR_DW-1:0] IE_IMPL = (SFR_DW'(1) << IE_WDT) | (SFR_DW'(1) << IE_OSC)
                                          | (SFR_DW'(1) << IE_NMI) | (SFR_DW'(1) << IE_ACCV);
endpackage

// File: rtl/sfr_bit_cell.sv
// Single storage bit with its own reset domain.
// Priority: domain reset, then hardware set, then software write.
// Assumes rst_n is synchronous, active low, already combined with stronger levels.
module sfr_bit_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wd_i,
    output logic q_o
);
    // Purpose: hold the bit, reset to its domain value, let the set event win over writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= RST_VAL;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (wr_i) begin
            q_o <= wd_i;
        end
    end
endmodule

// File: rtl/sfr_bus_port.sv
// Bus side: decodes the offset into write strobes and multiplexes read data.
// Assumes writes are allowed only when wr_ok_i is high (no reset level asserted).
module sfr_bus_port #(
    parameter int ADDR_W    = 4,
    parameter int IE_OFFSET = 0,
    parameter int FL_OFFSET = 1,
    parameter int DW        = 8
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_ok_i,
    input  logic [DW-1:0]     ie_i,
    input  logic [DW-1:0]     fl_i,
    output logic              ie_we_o,
    output logic              fl_we_o,
    output logic [DW-1:0]     rdata_o
);
    localparam logic [ADDR_W-1:0] IE_A = ADDR_W'(IE_OFFSET);
    localparam logic [ADDR_W-1:0] FL_A = ADDR_W'(FL_OFFSET);

    logic hit_ie;
    logic hit_fl;

    // Purpose: match the offset against the two register slots.
    always_comb begin
        hit_ie = sel_i && (addr_i == IE_A);
        hit_fl = sel_i && (addr_i == FL_A);
    end

    // Purpose: write strobes, suppressed while any reset is active.
    always_comb begin
        ie_we_o = hit_ie && wr_i && wr_ok_i;
        fl_we_o = hit_fl && wr_i && wr_ok_i;
    end

    // Purpose: combinational read mux, zero for unmapped offsets.
    always_comb begin
        rdata_o = '0;
        if (hit_ie) begin
            rdata_o = ie_i;
        end else if (hit_fl) begin
            rdata_o = fl_i;
        end
    end
endmodule

// File: rtl/sfr_enable_bank.sv
// Enable register: one cell per implemented position, constant zero elsewhere.
// Assumes all enable bits live in the power-up-clear domain.
module sfr_enable_bank #(
    parameter int              DW   = 8,
    parameter logic [DW-1:0]   IMPL = '0
) (
    input  logic          clk,
    input  logic          puc_dom_n,
    input  logic          we_i,
    input  logic [DW-1:0] wd_i,
    output logic [DW-1:0] q_o
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (IMPL[i]) begin : g_cell
            sfr_bit_cell #(.RST_VAL(1'b0)) cell_i (
                .clk   (clk),
                .rst_n (puc_dom_n),
                .set_i (1'b0),
                .wr_i  (we_i),
                .wd_i  (wd_i[i]),
                .q_o   (q_o[i])
            );
        end else begin : g_none
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sfr_flag_bank.sv
// Flag register: each flag sits in its own reset domain with its own set source.
// Assumes the domain inputs are already nested (stronger implies weaker).
module sfr_flag_bank
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              bor_dom_n,
    input  logic              por_dom_n,
    input  logic              puc_dom_n,
    input  logic              we_i,
    input  logic [SFR_DW-1:0] wd_i,
    input  logic              wdt_set_i,
    input  logic              osc_fault_i,
    input  logic              pin_rst_i,
    input  logic              nmi_edge_i,
    output logic [SFR_DW-1:0] q_o
);
    logic wdt_q, osc_q, bor_q, rst_q, nmi_q;

    sfr_bit_cell #(.RST_VAL(1'b0)) wdt_cell_i (
        .clk(clk), .rst_n(por_dom_n), .set_i(wdt_set_i),
        .wr_i(we_i), .wd_i(wd_i[FL_WDT]), .q_o(wdt_q)
    );

    sfr_bit_cell #(.RST_VAL(1'b1)) osc_cell_i (
        .clk(clk), .rst_n(puc_dom_n), .set_i(osc_fault_i),
        .wr_i(we_i), .wd_i(wd_i[FL_OSC]), .q_o(osc_q)
    );

    sfr_bit_cell #(.RST_VAL(1'b1)) bor_cell_i (
        .clk(clk), .rst_n(bor_dom_n), .set_i(1'b0),
        .wr_i(we_i), .wd_i(wd_i[FL_BOR]), .q_o(bor_q)
    );

    sfr_bit_cell #(.RST_VAL(1'b0)) rst_cell_i (
        .clk(clk), .rst_n(bor_dom_n), .set_i(pin_rst_i),
        .wr_i(we_i), .wd_i(wd_i[FL_RST]), .q_o(rst_q)
    );

    sfr_bit_cell #(.RST_VAL(1'b0)) nmi_cell_i (
        .clk(clk), .rst_n(puc_dom_n), .set_i(nmi_edge_i),
        .wr_i(we_i), .wd_i(wd_i[FL_NMI]), .q_o(nmi_q)
    );

    // Purpose: place the flags at their decoded positions, upper bits absent.
    always_comb begin
        q_o         = '0;
        q_o[FL_WDT] = wdt_q;
        q_o[FL_OSC] = osc_q;
        q_o[FL_BOR] = bor_q;
        q_o[FL_RST] = rst_q;
        q_o[FL_NMI] = nmi_q;
    end
endmodule

// File: rtl/sfr_intr_top.sv
// Top: interrupt enable and reset-cause flag registers with gated requests.
// Assumes the three reset inputs are synchronous to clk and active low;
// nesting of reset strength is resolved here, not required of the source.
module sfr_intr_top
    import sfr_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int IE_OFFSET = 0,
    parameter int FL_OFFSET = 1
) (
    input  logic              clk,
    input  logic              bor_n,
    input  logic              por_n,
    input  logic              puc_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SFR_DW-1:0] bus_wdata,
    output logic [SFR_DW-1:0] bus_rdata,
    input  logic              wdt_ovf_i,
    input  logic              wdt_key_err_i,
    input  logic              wdt_interval_i,
    input  logic              osc_fault_i,
    input  logic              pin_rst_i,
    input  logic              nmi_edge_i,
    input  logic              acc_viol_i,
    output logic              irq_wdt_o,
    output logic              irq_osc_o,
    output logic              irq_nmi_o,
    output logic              irq_accv_o
);
    logic              bor_dom_n, por_dom_n, puc_dom_n;
    logic              ie_we, fl_we;
    logic [SFR_DW-1:0] ie_q, fl_q;

    // Purpose: nest reset strength so a stronger level asserts all weaker domains.
    always_comb begin
        bor_dom_n = bor_n;
        por_dom_n = bor_n & por_n;
        puc_dom_n = bor_n & por_n & puc_n;
    end

    sfr_bus_port #(
        .ADDR_W(ADDR_W), .IE_OFFSET(IE_OFFSET), .FL_OFFSET(FL_OFFSET), .DW(SFR_DW)
    ) bus_i (
        .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wr_ok_i(puc_dom_n),
        .ie_i(ie_q), .fl_i(fl_q), .ie_we_o(ie_we), .fl_we_o(fl_we), .rdata_o(bus_rdata)
    );

    sfr_enable_bank #(.DW(SFR_DW), .IMPL(IE_IMPL)) ie_i (
        .clk(clk), .puc_dom_n(puc_dom_n), .we_i(ie_we), .wd_i(bus_wdata), .q_o(ie_q)
    );

    sfr_flag_bank fl_i (
        .clk(clk), .bor_dom_n(bor_dom_n), .por_dom_n(por_dom_n), .puc_dom_n(puc_dom_n),
        .we_i(fl_we), .wd_i(bus_wdata), .wdt_set_i(wdt_ovf_i | wdt_key_err_i),
        .osc_fault_i(osc_fault_i), .pin_rst_i(pin_rst_i), .nmi_edge_i(nmi_edge_i),
        .q_o(fl_q)
    );

    // Purpose: gate each flag with its enable; watchdog only in interval mode.
    always_comb begin
        irq_wdt_o  = ie_q[IE_WDT] & fl_q[FL_WDT] & wdt_interval_i;
        irq_osc_o  = ie_q[IE_OSC] & fl_q[FL_OSC];
        irq_nmi_o  = ie_q[IE_NMI] & fl_q[FL_NMI];
        irq_accv_o = ie_q[IE_ACCV] & acc_viol_i;
    end
endmodule

// File: rtl/sfr_intr_chk.sv
// Checker for sfr_intr_top, attached by bind. Armed after the first brown-out edge.
module sfr_intr_chk #(
    parameter int ADDR_W    = 4,
    parameter int IE_OFFSET = 0,
    parameter int FL_OFFSET = 1
) (
    input logic              clk,
    input logic              bor_n,
    input logic              por_n,
    input logic              puc_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              wdt_ovf_i,
    input logic              wdt_key_err_i,
    input logic              wdt_interval_i,
    input logic              osc_fault_i,
    input logic              nmi_edge_i,
    input logic              irq_wdt_o,
    input logic [7:0]        ie_q,
    input logic [7:0]        fl_q
);
    logic armed = 1'b0;

    // Purpose: arm the properties once a full reset has been seen.
    always_ff @(posedge clk) begin
        if (!bor_n) armed <= 1'b1;
    end

    logic fl_wr;
    assign fl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(FL_OFFSET));

    AST_IE_GAPS_ZERO: assert property (@(posedge clk) disable iff (!armed)
        (bus_sel && bus_addr == ADDR_W'(IE_OFFSET)) |-> ((bus_rdata & 8'hCC) == 8'h00)); // R1
    AST_FL_TOP_ZERO: assert property (@(posedge clk) disable iff (!armed)
        (bus_sel && bus_addr == ADDR_W'(FL_OFFSET)) |-> (bus_rdata[7:5] == 3'b000)); // R8
    AST_WDT_KEEPS_ON_PUC: assert property (@(posedge clk) disable iff (!armed)
        (bor_n && por_n && !puc_n && !wdt_ovf_i && !wdt_key_err_i) |=> (fl_q[0] == $past(fl_q[0]))); // R3
    AST_OSC_HELD: assert property (@(posedge clk) disable iff (!armed)
        osc_fault_i |=> fl_q[1]); // R4
    AST_BOR_FLAG_SET: assert property (@(posedge clk) disable iff (!armed)
        !bor_n |=> fl_q[2]); // R5
    AST_RST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!armed)
        (bor_n && fl_q[3] && !fl_wr) |=> fl_q[3]); // R6
    AST_NMI_SET_WINS: assert property (@(posedge clk) disable iff (!armed)
        (bor_n && por_n && puc_n && nmi_edge_i) |=> fl_q[4]); // R9
    AST_WDT_IRQ_MODE: assert property (@(posedge clk) disable iff (!armed)
        !wdt_interval_i |-> !irq_wdt_o); // R10
    AST_POR_DEFAULTS: assert property (@(posedge clk) disable iff (!armed)
        !por_n |=> (fl_q[0] == 1'b0 && ie_q == 8'h00 && fl_q[1])); // R12
endmodule

bind sfr_intr_top sfr_intr_chk #(
    .ADDR_W(ADDR_W), .IE_OFFSET(IE_OFFSET), .FL_OFFSET(FL_OFFSET)
) chk_i (
    .clk(clk), .bor_n(bor_n), .por_n(por_n), .puc_n(puc_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .wdt_ovf_i(wdt_ovf_i), .wdt_key_err_i(wdt_key_err_i), .wdt_interval_i(wdt_interval_i),
    .osc_fault_i(osc_fault_i), .nmi_edge_i(nmi_edge_i), .irq_wdt_o(irq_wdt_o),
    .ie_q(ie_q), .fl_q(fl_q)
);

// File: tb/sfr_intr_top_tb_top.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module sfr_intr_top_tb_top;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic bor_n, por_n, puc_n;
    logic bus_sel, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic wdt_ovf, wdt_key, wdt_int, osc_f, pin_rst, nmi_e, accv;
    logic irq_wdt, irq_osc, irq_nmi, irq_accv;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] m_ie, m_fl;

    always #2 clk = ~clk;

    sfr_intr_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .bor_n(bor_n), .por_n(por_n), .puc_n(puc_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_ovf_i(wdt_ovf), .wdt_key_err_i(wdt_key),
        .wdt_interval_i(wdt_int), .osc_fault_i(osc_f), .pin_rst_i(pin_rst),
        .nmi_edge_i(nmi_e), .acc_viol_i(accv), .irq_wdt_o(irq_wdt), .irq_osc_o(irq_osc),
        .irq_nmi_o(irq_nmi), .irq_accv_o(irq_accv)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Reference model step, evaluated with the inputs present at the clock edge.
    task automatic model_step();
        bit b, p, u, wi, wf;
        logic [7:0] n;
        b  = !bor_n;
        p  = b || !por_n;
        u  = p || !puc_n;
        wi = !u && bus_sel && bus_wr && bus_addr == 0;
        wf = !u && bus_sel && bus_wr && bus_addr == 1;
        n = m_fl;
        if (p) n[0] = 0; else if (wdt_ovf || wdt_key) n[0] = 1; else if (wf) n[0] = bus_wdata[0];
        if (u) n[1] = 1; else if (osc_f) n[1] = 1; else if (wf) n[1] = bus_wdata[1];
        if (b) n[2] = 1; else if (wf) n[2] = bus_wdata[2];
        if (b) n[3] = 0; else if (pin_rst) n[3] = 1; else if (wf) n[3] = bus_wdata[3];
        if (u) n[4] = 0; else if (nmi_e) n[4] = 1; else if (wf) n[4] = bus_wdata[4];
        n[7:5] = 3'b000;
        m_fl = n;
        if (u) m_ie = 8'h00; else if (wi) m_ie = bus_wdata & 8'h33;
    endtask

    task automatic compare();
        logic [7:0] er;
        logic [3:0] eq;
        er = 8'h00;
        if (bus_sel && bus_addr == 0) er = m_ie;
        else if (bus_sel && bus_addr == 1) er = m_fl;
        eq = {m_ie[5] & accv, m_ie[4] & m_fl[4], m_ie[1] & m_fl[1], m_ie[0] & m_fl[0] & wdt_int};
        chk("R2 rdata vs model", bus_rdata, er);
        chk("R10 irq vs model", {4'h0, irq_accv, irq_nmi, irq_osc, irq_wdt}, {4'h0, eq});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, e);
        bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bor_n = 0; por_n = 0; puc_n = 0;
        bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        wdt_ovf = 0; wdt_key = 0; wdt_int = 0; osc_f = 0; pin_rst = 0; nmi_e = 0; accv = 0;
        m_ie = 'x; m_fl = 'x;
        @(posedge clk); model_step();
        @(posedge clk); model_step();
        #1;
        bor_n = 1; por_n = 1; puc_n = 1;
        tick();
        rd(0, 8'h00, "R1 R12 enables after brown-out");
        rd(1, 8'h06, "R5 R4 R12 flags after brown-out");
        wr(0, 8'hFF);  rd(0, 8'h33, "R1 only implemented enables");
        wr(5, 8'hFF);  rd(5, 8'h00, "R2 unmapped offset reads zero");
        rd(0, 8'h33, "R2 unmapped write left enables");
        wr(1, 8'h00);  rd(1, 8'h00, "R5 R4 software clear");
        wr(1, 8'hFF);  rd(1, 8'h1F, "R8 upper flag bits absent");
        wr(1, 8'h00);
        osc_f = 1; tick(); wr(1, 8'h00);
        rd(1, 8'h02, "R4 clear blocked by fault");
        chk("R10 osc irq", {7'b0, irq_osc}, 8'h01);
        osc_f = 0; wr(1, 8'h00); rd(1, 8'h00, "R4 clear after fault gone");
        nmi_e = 1; wr(1, 8'h00); nmi_e = 0;
        rd(1, 8'h10, "R9 R7 set beats clearing write");
        chk("R10 nmi irq", {7'b0, irq_nmi}, 8'h01);
        wdt_ovf = 1; tick(); wdt_ovf = 0; wdt_int = 0; tick();
        chk("R10 watchdog irq blocked in watchdog mode", {7'b0, irq_wdt}, 8'h00);
        wdt_int = 1; #1;
        chk("R10 watchdog irq in interval mode", {7'b0, irq_wdt}, 8'h01);
        rd(1, 8'h11, "R3 overflow sets flag");
        accv = 1; #1;
        chk("R10 access violation irq", {7'b0, irq_accv}, 8'h01);
        accv = 0;
        pin_rst = 1; tick(); pin_rst = 0;
        rd(1, 8'h19, "R6 pin reset sets flag");
        wr(1, 8'h08); wdt_key = 1; tick(); wdt_key = 0;
        rd(1, 8'h09, "R3 key violation sets flag");
        puc_n = 0; wr(1, 8'h00); wr(0, 8'h33); puc_n = 1; tick();
        rd(1, 8'h0B, "R3 R7 R11 flags after power-up-clear");
        rd(0, 8'h00, "R1 R11 enables after power-up-clear");
        wr(1, 8'h0D);
        por_n = 0; tick(); por_n = 1; tick();
        rd(1, 8'h0E, "R3 R5 R6 R12 flags after power-on");
        bor_n = 0; tick(); bor_n = 1; tick();
        rd(1, 8'h06, "R6 R12 flags after brown-out");
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 999));
            bor_n = (r != 7); por_n = (r != 11) && (r != 12); puc_n = (r % 97) != 5;
            wdt_ovf = ($urandom_range(0, 15) == 0); wdt_key = ($urandom_range(0, 31) == 0);
            wdt_int = $urandom_range(0, 1) == 1; osc_f = ($urandom_range(0, 7) == 0);
            pin_rst = ($urandom_range(0, 31) == 0); nmi_e = ($urandom_range(0, 15) == 0);
            accv = $urandom_range(0, 1) == 1;
            bus_sel = $urandom_range(0, 1) == 1; bus_wr = $urandom_range(0, 1) == 1;
            bus_addr = AW'($urandom_range(0, 3)); bus_wdata = 8'($urandom);
            tick();
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule